// File: doc/BRIEF.md
# Prescaled Match Timer

This block is a counter peripheral with a small register port. A prescale counter divides an external count-tick strobe. Each time the prescaler wraps, the main counter advances by one. The main counter is compared against a set of match registers, four by default. When the counter reaches a channel's match value, that channel can do any combination of three things: raise a pending flag that feeds the interrupt line, send the counter back to zero on its next advance, or stop counting. Each channel also drives one output pin. On a match, the pin is left alone, forced low, forced high or inverted, according to a two-bit action code.

Software programs the block through a single-cycle write port. Reads return data one cycle after the request. Pending flags are cleared by writing ones to the flag word. Capture and input-edge logic belong to a companion block. The flag bits reserved for capture events therefore always read as zero here.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads zero, `irq` is 0, every `match_pin` is 0 and `bus_rdata` is 0.
- R2: While counting is enabled, each `count_tick` either raises the prescale count by one or, when the prescale count equals the prescale limit, clears it to zero and advances the main counter. The main counter therefore moves once every limit+1 ticks. Ticks have no effect while counting is disabled.
- R3: Control word (address 1): bit 0 enables counting, and bit 1 holds the main counter and the prescale count at zero for as long as it is set.
- R4: A channel's match event occurs only when the counter is advanced by a tick into a value equal to that channel's match register (addresses 8+n). Idle cycles, and ticks that only move the prescaler while the counter rests on that value, cause no further event.
- R5: Match action word (address 5) holds three bits per channel n. Bit 3n set makes a match event of channel n set pending flag n, which is bit n of the flag word (address 0). Flag word bits 4 to 7 always read 0. `irq` is the OR of the pending flags.
- R6: Writing the flag word clears each flag whose data bit is 1 and leaves flags under 0 bits unchanged. A match event in the same cycle as a clear of the same flag leaves the flag set.
- R7: With bit 3n+1 set, an advance taken while the counter equals match register n loads zero instead of the incremented value.
- R8: With bit 3n+2 set, a match event of channel n clears the enable bit. The main counter and the prescale count then hold their values until software sets the enable bit again.
- R9: Pin word (address 6): bits [3:0] are the software-loadable pin states. Bits [2n+9:2n+8] hold channel n's action on a match event: 0 keeps the pin, 1 drives it low, 2 drives it high, 3 inverts it.
- R10: Other addresses: 2 is the main counter, 3 is the prescale limit and 4 is the prescale count, all readable and writable. A read request returns its word on `bus_rdata` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| count_tick | input | 1 | Count strobe from the count-source logic |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | OR of pending match flags |
| match_pin | output | N_MATCH | Match output pins |

## Verification
A table of prescale limits and tick counts is run with all match actions off. Its entries include limit zero, a tick count one short of a wrap and exact multiples of the period. Together they separate an off-by-one in the wrap compare from an error in the remainder kept in the prescale count.

Directed sequences then cover the other behaviour:
- Auto-reset, where the counter must land on zero rather than the match value plus one.
- Stop, where the counter is frozen at the match value with the prescaler at zero, followed by a restart.
- The write-one clear, including a clear that collides with a new event.
- All four pin actions, including a toggle channel left on its match value over extra prescale ticks, which would expose a repeated event.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] ADR_FLAGS = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_CTRL  = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_COUNT = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_PSLIM = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_PSCNT = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_ACT   = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_PIN   = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_MATCH = 4'd8;

  localparam int unsigned PIN_ACT_LSB = 8;

  typedef enum logic [1:0] {
    PIN_KEEP = 2'd0,
    PIN_LOW  = 2'd1,
    PIN_HIGH = 2'd2,
    PIN_FLIP = 2'd3
  } pin_act_e;
endpackage

// File: rtl/mtmr_counter.sv
module mtmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             ctrl_we_i,
  input  logic [1:0]       ctrl_wdata_i,
  input  logic             tc_we_i,
  input  logic             pc_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] pr_i,
  input  logic             rst_hit_i,
  input  logic             stop_hit_i,
  output logic [CNT_W-1:0] tc_o,
  output logic [CNT_W-1:0] pc_o,
  output logic [CNT_W-1:0] tc_next_o,
  output logic             step_o,
  output logic             run_o,
  output logic             hold_o
);
  logic [CNT_W-1:0] tc_q, pc_q;
  logic             run_q, hold_q;
  logic             active, wrap;

  assign active    = run_q && !hold_q && tick_i;
  assign wrap      = (pc_q == pr_i);
  assign step_o    = active && wrap && !tc_we_i;
  assign tc_next_o = rst_hit_i ? '0 : tc_q + 1'b1;
  assign tc_o      = tc_q;
  assign pc_o      = pc_q;
  assign run_o     = run_q;
  assign hold_o    = hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tc_q   <= '0;
      pc_q   <= '0;
      run_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (ctrl_we_i) begin
        run_q  <= ctrl_wdata_i[0];
        hold_q <= ctrl_wdata_i[1];
      end else if (stop_hit_i) begin
        run_q <= 1'b0;
      end
      if (hold_q) begin
        tc_q <= '0;
        pc_q <= '0;
      end else begin
        if (tc_we_i)     tc_q <= wdata_i;
        else if (step_o) tc_q <= tc_next_o;
        if (pc_we_i)     pc_q <= wdata_i;
        else if (active) pc_q <= wrap ? '0 : pc_q + 1'b1;
      end
    end
  end

  // R3: hold forces both counts to zero
  assert_hold_zero_R3: assert property (@(posedge clk) disable iff (rst)
    hold_q |=> (tc_q == '0 && pc_q == '0));

  // R2: without a tick, a write or a hold, the counter keeps its value
  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (rst)
    (!active && !tc_we_i && !hold_q) |=> $stable(tc_q));

  // R2: a wrap step leaves the prescale count at zero
  assert_wrap_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (step_o && !pc_we_i) |=> (pc_q == '0));

  // R8: a stop event clears the enable bit
  assert_stop_clears_run_R8: assert property (@(posedge clk) disable iff (rst)
    (stop_hit_i && !ctrl_we_i) |=> !run_q);
endmodule

// File: rtl/mtmr_match_unit.sv
module mtmr_match_unit
  import mtmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] tc_i,
  input  logic [CNT_W-1:0] tc_next_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] mr_i,
  input  pin_act_e         act_i,
  input  logic             pin_we_i,
  input  logic             pin_wval_i,
  output logic             eq_o,
  output logic             hit_o,
  output logic             pin_o
);
  logic pin_q;

  assign eq_o  = (tc_i == mr_i);
  assign hit_o = step_i && (tc_next_i == mr_i);
  assign pin_o = pin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
    end else if (pin_we_i) begin
      pin_q <= pin_wval_i;
    end else if (hit_o) begin
      case (act_i)
        PIN_LOW:  pin_q <= 1'b0;
        PIN_HIGH: pin_q <= 1'b1;
        PIN_FLIP: pin_q <= ~pin_q;
        default:  pin_q <= pin_q;
      endcase
    end
  end

  // R9: pin actions on a match event
  assert_pin_high_R9: assert property (@(posedge clk) disable iff (rst)
    (hit_o && !pin_we_i && act_i == PIN_HIGH) |=> pin_q);
  assert_pin_low_R9: assert property (@(posedge clk) disable iff (rst)
    (hit_o && !pin_we_i && act_i == PIN_LOW) |=> !pin_q);
  assert_pin_flip_R9: assert property (@(posedge clk) disable iff (rst)
    (hit_o && !pin_we_i && act_i == PIN_FLIP) |=> (pin_q != $past(pin_q)));
  // R4: no event means the pin keeps its state
  assert_pin_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (!hit_o && !pin_we_i) |=> $stable(pin_q));
endmodule

// File: rtl/mtmr_regs.sv
module mtmr_regs
  import mtmr_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            bus_sel,
  input  logic                            bus_wr,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [DATA_W-1:0]               bus_wdata,
  input  logic [CNT_W-1:0]                tc_i,
  input  logic [CNT_W-1:0]                pc_i,
  input  logic                            run_i,
  input  logic                            hold_i,
  input  logic [N_MATCH-1:0]              pins_i,
  input  logic [N_MATCH-1:0]              hit_i,
  output logic [DATA_W-1:0]               rdata_o,
  output logic                            irq_o,
  output logic [N_MATCH-1:0][CNT_W-1:0]   mr_o,
  output logic [N_MATCH-1:0]              int_en_o,
  output logic [N_MATCH-1:0]              rst_en_o,
  output logic [N_MATCH-1:0]              stop_en_o,
  output logic [N_MATCH-1:0][1:0]         act_o,
  output logic [CNT_W-1:0]                pr_o,
  output logic                            ctrl_we_o,
  output logic                            tc_we_o,
  output logic                            pc_we_o,
  output logic                            pin_we_o
);
  localparam int ACT_W = 3 * N_MATCH;

  logic [N_MATCH-1:0][CNT_W-1:0] mr_q;
  logic [ACT_W-1:0]              mcr_q;
  logic [N_MATCH-1:0][1:0]       pact_q;
  logic [CNT_W-1:0]              pr_q;
  logic [N_MATCH-1:0]            flags_q, flags_set, flags_clr, flags_nxt;
  logic                          irq_q;
  logic [DATA_W-1:0]             rd_word, rdata_q;
  logic                          wr;

  assign wr        = bus_sel && bus_wr;
  assign ctrl_we_o = wr && bus_addr == ADR_CTRL;
  assign tc_we_o   = wr && bus_addr == ADR_COUNT;
  assign pc_we_o   = wr && bus_addr == ADR_PSCNT;
  assign pin_we_o  = wr && bus_addr == ADR_PIN;

  genvar g;
  generate
    for (g = 0; g < N_MATCH; g++) begin : g_fields
      assign int_en_o[g]  = mcr_q[3*g];
      assign rst_en_o[g]  = mcr_q[3*g+1];
      assign stop_en_o[g] = mcr_q[3*g+2];
    end
  endgenerate

  assign mr_o    = mr_q;
  assign act_o   = pact_q;
  assign pr_o    = pr_q;
  assign irq_o   = irq_q;
  assign rdata_o = rdata_q;

  assign flags_set = hit_i & int_en_o;
  assign flags_clr = (wr && bus_addr == ADR_FLAGS) ? bus_wdata[N_MATCH-1:0] : '0;
  assign flags_nxt = (flags_q & ~flags_clr) | flags_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      mr_q    <= '0;
      mcr_q   <= '0;
      pact_q  <= '0;
      pr_q    <= '0;
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_nxt;
      irq_q   <= |flags_nxt;
      if (wr && bus_addr == ADR_ACT)   mcr_q <= bus_wdata[ACT_W-1:0];
      if (wr && bus_addr == ADR_PSLIM) pr_q  <= bus_wdata[CNT_W-1:0];
      if (pin_we_o)
        for (int n = 0; n < N_MATCH; n++)
          pact_q[n] <= bus_wdata[PIN_ACT_LSB+2*n +: 2];
      for (int n = 0; n < N_MATCH; n++)
        if (wr && bus_addr == ADR_MATCH + ADDR_W'(n))
          mr_q[n] <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_word = '0;
    case (bus_addr)
      ADR_FLAGS: rd_word[N_MATCH-1:0] = flags_q;
      ADR_CTRL:  rd_word[1:0] = {hold_i, run_i};
      ADR_COUNT: rd_word[CNT_W-1:0] = tc_i;
      ADR_PSLIM: rd_word[CNT_W-1:0] = pr_q;
      ADR_PSCNT: rd_word[CNT_W-1:0] = pc_i;
      ADR_ACT:   rd_word[ACT_W-1:0] = mcr_q;
      ADR_PIN: begin
        rd_word[N_MATCH-1:0] = pins_i;
        for (int n = 0; n < N_MATCH; n++)
          rd_word[PIN_ACT_LSB+2*n +: 2] = pact_q[n];
      end
      default: begin
        for (int n = 0; n < N_MATCH; n++)
          if (bus_addr == ADR_MATCH + ADDR_W'(n))
            rd_word[CNT_W-1:0] = mr_q[n];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                     rdata_q <= '0;
    else if (bus_sel && !bus_wr) rdata_q <= rd_word;
  end

  // R6: cleared bits with no colliding event drop
  assert_w1c_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_q & $past(flags_clr & ~flags_set)) == '0));
  // R5: an enabled event always leaves its flag set
  assert_event_sets_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_q & $past(flags_set)) == $past(flags_set)));
  // R5: interrupt line follows the pending flags
  assert_irq_or_R5: assert property (@(posedge clk) disable iff (rst)
    irq_q == (flags_q != '0));
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mtmr_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               count_tick,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [3:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq,
  output logic [N_MATCH-1:0] match_pin
);
  logic [N_MATCH-1:0][CNT_W-1:0] mr;
  logic [N_MATCH-1:0][1:0]       act;
  logic [N_MATCH-1:0]            int_en, rst_en, stop_en, eq, hit;
  logic [CNT_W-1:0]              tc, pc, tc_next, pr;
  logic step, run, hold, ctrl_we, tc_we, pc_we, pin_we;
  logic rst_hit, stop_hit;

  assign rst_hit  = |(eq & rst_en);
  assign stop_hit = |(hit & stop_en);

  mtmr_regs #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .tc_i(tc), .pc_i(pc), .run_i(run), .hold_i(hold),
    .pins_i(match_pin), .hit_i(hit),
    .rdata_o(bus_rdata), .irq_o(irq), .mr_o(mr),
    .int_en_o(int_en), .rst_en_o(rst_en), .stop_en_o(stop_en),
    .act_o(act), .pr_o(pr), .ctrl_we_o(ctrl_we), .tc_we_o(tc_we),
    .pc_we_o(pc_we), .pin_we_o(pin_we)
  );

  mtmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(count_tick),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(bus_wdata[1:0]),
    .tc_we_i(tc_we), .pc_we_i(pc_we), .wdata_i(bus_wdata[CNT_W-1:0]),
    .pr_i(pr), .rst_hit_i(rst_hit), .stop_hit_i(stop_hit),
    .tc_o(tc), .pc_o(pc), .tc_next_o(tc_next), .step_o(step),
    .run_o(run), .hold_o(hold)
  );

  genvar g;
  generate
    for (g = 0; g < N_MATCH; g++) begin : g_ch
      mtmr_match_unit #(.CNT_W(CNT_W)) u_ch (
        .clk(clk), .rst(rst), .tc_i(tc), .tc_next_i(tc_next),
        .step_i(step), .mr_i(mr[g]), .act_i(pin_act_e'(act[g])),
        .pin_we_i(pin_we), .pin_wval_i(bus_wdata[g]),
        .eq_o(eq[g]), .hit_o(hit[g]), .pin_o(match_pin[g])
      );
    end
  endgenerate

  // R7: an auto-reset advance lands on zero
  assert_auto_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (step && rst_hit && !hold) |=> (tc == '0));
endmodule

// File: tb/match_timer_test.sv
module match_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        count_tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [3:0]  match_pin;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [3:0] A_FLAGS = 4'd0, A_CTRL = 4'd1, A_COUNT = 4'd2,
                         A_PSLIM = 4'd3, A_PSCNT = 4'd4, A_ACT = 4'd5,
                         A_PIN = 4'd6, A_M0 = 4'd8;

  typedef struct packed {
    logic [31:0] lim;
    logic [31:0] ticks;
    logic [31:0] exp_tc;
    logic [31:0] exp_pc;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{32'd0, 32'd5,  32'd5, 32'd0},
    '{32'd1, 32'd5,  32'd2, 32'd1},
    '{32'd3, 32'd10, 32'd2, 32'd2},
    '{32'd2, 32'd9,  32'd3, 32'd0},
    '{32'd4, 32'd4,  32'd0, 32'd4},
    '{32'd7, 32'd17, 32'd2, 32'd1}
  };

  match_timer uut (
    .clk(clk), .rst(rst), .count_tick(count_tick), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .match_pin(match_pin)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      count_tick = 1'b1;
    end
    @(negedge clk);
    count_tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 pins", {28'd0, match_pin}, 32'd0);
    chk("R1 rdata", bus_rdata, 32'd0);
    rd_reg(A_FLAGS, d); chk("R1 flags", d, 32'd0);
    rd_reg(A_COUNT, d); chk("R1 count", d, 32'd0);
    rd_reg(A_CTRL, d);  chk("R1 ctrl", d, 32'd0);
    rd_reg(A_PIN, d);   chk("R1 pin word", d, 32'd0);

    // R2 / R10 prescale table
    for (int v = 0; v < NVEC; v++) begin
      wr_reg(A_CTRL, 32'd2);
      wr_reg(A_PSLIM, VEC[v].lim);
      wr_reg(A_ACT, 32'd0);
      wr_reg(A_CTRL, 32'd1);
      ticks(int'(VEC[v].ticks));
      wr_reg(A_CTRL, 32'd0);
      rd_reg(A_COUNT, d); chk("R2 table count", d, VEC[v].exp_tc);
      rd_reg(A_PSCNT, d); chk("R10 table prescale count", d, VEC[v].exp_pc);
    end

    // R2 ticks ignored while disabled
    ticks(4);
    rd_reg(A_COUNT, d); chk("R2 disabled count", d, 32'd2);

    // R3 hold forces zero even with enable set
    wr_reg(A_COUNT, 32'd7);
    rd_reg(A_COUNT, d); chk("R10 count write", d, 32'd7);
    wr_reg(A_CTRL, 32'd3);
    ticks(3);
    rd_reg(A_COUNT, d); chk("R3 hold count", d, 32'd0);
    rd_reg(A_PSCNT, d); chk("R3 hold prescale", d, 32'd0);

    // R7 / R5 auto-reset with flag
    wr_reg(A_PSLIM, 32'd0);
    wr_reg(A_M0, 32'd3);
    wr_reg(A_ACT, 32'd3);
    wr_reg(A_CTRL, 32'd1);
    ticks(4);
    rd_reg(A_COUNT, d); chk("R7 wrap to zero", d, 32'd0);
    rd_reg(A_FLAGS, d); chk("R5 flag set", d, 32'd1);
    chk("R5 irq high", {31'd0, irq}, 32'd1);
    ticks(1);
    rd_reg(A_COUNT, d); chk("R7 after wrap", d, 32'd1);

    // R6 write 0 keeps, write 1 clears
    wr_reg(A_FLAGS, 32'd0);
    rd_reg(A_FLAGS, d); chk("R6 zero write keeps", d, 32'd1);
    wr_reg(A_FLAGS, 32'd1);
    rd_reg(A_FLAGS, d); chk("R6 one write clears", d, 32'd0);
    chk("R6 irq low", {31'd0, irq}, 32'd0);

    // R8 stop on match, then restart
    wr_reg(A_CTRL, 32'd2);
    wr_reg(A_PSLIM, 32'd1);
    wr_reg(A_M0 + 4'd1, 32'd2);
    wr_reg(A_ACT, 32'h20);
    wr_reg(A_CTRL, 32'd1);
    ticks(10);
    rd_reg(A_COUNT, d); chk("R8 stopped count", d, 32'd2);
    rd_reg(A_PSCNT, d); chk("R8 stopped prescale", d, 32'd0);
    rd_reg(A_CTRL, d);  chk("R8 enable cleared", d, 32'd0);
    wr_reg(A_CTRL, 32'd1);
    ticks(2);
    rd_reg(A_COUNT, d); chk("R8 restart", d, 32'd3);

    // R6 event wins over same-cycle clear
    wr_reg(A_CTRL, 32'd2);
    wr_reg(A_PSLIM, 32'd0);
    wr_reg(A_M0, 32'd1);
    wr_reg(A_ACT, 32'd1);
    wr_reg(A_FLAGS, 32'hF);
    wr_reg(A_CTRL, 32'd1);
    @(negedge clk);
    count_tick = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_FLAGS; bus_wdata = 32'd1;
    @(negedge clk);
    count_tick = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    rd_reg(A_FLAGS, d); chk("R6 event beats clear", d, 32'd1);
    wr_reg(A_FLAGS, 32'hFF);
    rd_reg(A_FLAGS, d); chk("R5 capture bits zero", d, 32'd0);

    // R9 / R4 pin actions
    wr_reg(A_CTRL, 32'd2);
    wr_reg(A_ACT, 32'd0);
    for (int n = 0; n < 4; n++) wr_reg(A_M0 + 4'(n), 32'd5);
    wr_reg(A_PIN, 32'h1E0C);
    chk("R9 pin load", {28'd0, match_pin}, 32'hC);
    wr_reg(A_CTRL, 32'd1);
    ticks(5);
    chk("R9 pin actions", {28'd0, match_pin}, 32'hB);
    rd_reg(A_PIN, d); chk("R9 pin word", d, 32'h1E0B);
    wr_reg(A_PSLIM, 32'd3);
    wr_reg(A_COUNT, 32'd4);
    ticks(4);
    chk("R9 toggle again", {28'd0, match_pin}, 32'h9);
    ticks(3);
    chk("R4 single event per value", {28'd0, match_pin}, 32'h9);
    repeat (4) @(negedge clk);
    chk("R4 idle no event", {28'd0, match_pin}, 32'h9);

    finish_run();
  end
endmodule